// File: doc/BRIEF.md
# Power-Up Reset and Oscillator Settle Sequencer

This block turns a power-good detect and a board-level active-low reset button into the internal reset of a chip. It runs off the raw oscillator clock. After the analog detector lets go, the block counts out a fixed power-on hold. It then enables the internal clocks and counts out a second, longer interval for the oscillator to settle. Only after that does it release the internal reset, and program execution begins.

The block also drives the high-impedance controls for three groups of pads, each of which goes high-impedance at a different point of the sequence. Group A is high-impedance for the whole time internal reset is applied. Group B is high-impedance during the power-on hold only while the external reset is asserted, and from the end of the hold until release. Group C is never forced during the power-on hold; it goes high-impedance when the hold ends and the clocks start. The external reset passes through a synchronizer. Asserting it at any time after the hold ends restarts the settle interval.

Both interval lengths are powers of two, with parameter exponents. The defaults give 2^17 and 2^18 oscillator cycles: 8.192 ms and 16.384 ms at 16 MHz.

Top module: `pwrup_seq`

## Requirements
- R1: After `por_det` falls, `clk_en` stays 0 and then rises at the 2^POR_EXP-th rising clock edge. `int_rst_n` stays 0 throughout this hold.
- R2: When no external reset occurs, `int_rst_n` rises exactly 2^STAB_EXP rising edges after `clk_en` rose.
- R3: `ext_rst_n` passes through SYNC_STAGES flops (2 by default). A low level that is stable before a rising edge first affects the outputs after the second rising edge.
- R4: An external reset held during the power-on hold does not change the hold's length.
- R5: If the external reset is asserted during the settle interval, the interval restarts. `int_rst_n` rises 2^STAB_EXP edges after the first edge at which the synchronized reset reads released.
- R6: If the external reset is asserted after release, `int_rst_n` drops and a full settle interval is run again. `clk_en` stays 1.
- R7: Every bit of `hiz_a` is 1 exactly when `int_rst_n` is 0.
- R8: During the power-on hold, `hiz_b` equals the synchronized external reset. From the end of the hold until release, all of its bits are 1.
- R9: `hiz_c` is all 0 during the power-on hold and all 1 from the end of the hold until release.
- R10: `por_det` high acts asynchronously, without a clock edge. It forces `clk_en`=0, `int_rst_n`=0, `hiz_a` all 1, `hiz_b` all 0 and `hiz_c` all 0, and it restarts the hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Raw oscillator clock |
| por_det | input | 1 | Power-on detect, active high, asynchronous |
| ext_rst_n | input | 1 | External reset, active low, asynchronous to the clock |
| int_rst_n | output | 1 | Internal reset, active low |
| clk_en | output | 1 | Internal clock enable |
| hiz_a | output | GA_W | High-impedance enables, group A |
| hiz_b | output | GB_W | High-impedance enables, group B |
| hiz_c | output | GC_W | High-impedance enables, group C |

## Verification
The assertions assume three things about the inputs:
- `por_det` is high from time zero until the sequencer has been initialised.
- The oscillator is the only clock.
- `ext_rst_n` reaches the synchronizer as a level, not as a glitch that is shorter than a cycle.

The stimulus keeps within these assumptions. It raises `por_det` before the first edge and holds it for several cycles. It changes `ext_rst_n` and `por_det` only one nanosecond after a rising edge or on a falling edge. Each external reset level is held for at least one full cycle. The intervals are shortened through the exponent parameters, so every edge-exact boundary is reached in a few hundred cycles.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

   typedef enum logic [1:0] {
      PH_HOLD   = 2'd0,
      PH_SETTLE = 2'd1,
      PH_RUN    = 2'd2
   } phase_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pwrup_seq_sync.sv
module pwrup_seq_sync #(
   parameter int unsigned STAGES   = 2,
   parameter logic        INIT_VAL = 1'b1
) (
   input  logic clk,
   input  logic arst,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pwrup_seq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) chain[0] <= INIT_VAL;
      else      chain[0] <= d_i;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or posedge arst) begin
            if (arst) chain[s] <= INIT_VAL;
            else      chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/pwrup_seq_fsm.sv
module pwrup_seq_fsm
   import pwrup_seq_pkg::*;
#(
   parameter int unsigned POR_EXP  = 17,
   parameter int unsigned STAB_EXP = 18
) (
   input  logic   clk,
   input  logic   arst,
   input  logic   ext_act_i,
   output phase_e phase_o
);

   localparam int unsigned CW = max_u(POR_EXP, STAB_EXP);
   localparam logic [CW-1:0] HOLD_LAST   = CW'((64'd1 << POR_EXP) - 64'd1);
   localparam logic [CW-1:0] SETTLE_LAST = CW'((64'd1 << STAB_EXP) - 64'd1);

   generate
      if (POR_EXP < 1 || POR_EXP > 30) begin : g_bad_por
         $error("pwrup_seq_fsm: POR_EXP out of range 1..30");
      end
      if (STAB_EXP < 1 || STAB_EXP > 30) begin : g_bad_stab
         $error("pwrup_seq_fsm: STAB_EXP out of range 1..30");
      end
   endgenerate

   phase_e        phase;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         phase <= PH_HOLD;
         cnt   <= '0;
      end else begin
         unique case (phase)
            PH_HOLD: begin
               if (cnt == HOLD_LAST) begin
                  phase <= PH_SETTLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_SETTLE: begin
               if (ext_act_i) begin
                  cnt <= '0;
               end else if (cnt == SETTLE_LAST) begin
                  phase <= PH_RUN;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_RUN: begin
               cnt <= '0;
               if (ext_act_i) phase <= PH_SETTLE;
            end
            default: begin
               phase <= PH_HOLD;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign phase_o = phase;

   // R1: the hold counter advances by one on every edge until it leaves the hold
   assert_hold_step_R1: assert property (@(posedge clk) disable iff (arst)
      (phase == PH_HOLD) |=> (phase == PH_SETTLE || cnt == $past(cnt) + 1'b1));

   // R2: release is reached only from the settle phase
   assert_release_from_settle_R2: assert property (@(posedge clk) disable iff (arst)
      (phase == PH_RUN && $past(phase) != PH_RUN) |-> $past(phase) == PH_SETTLE);

   // R6: an external reset seen while running returns to settle on the next edge
   assert_ext_restart_R6: assert property (@(posedge clk) disable iff (arst)
      (phase == PH_RUN && ext_act_i) |=> (phase == PH_SETTLE && cnt == '0));

   // R5: an external reset seen during settle holds the counter at zero
   assert_settle_hold_R5: assert property (@(posedge clk) disable iff (arst)
      (phase == PH_SETTLE && ext_act_i) |=> (phase == PH_SETTLE && cnt == '0));

   // R4: the hold phase never goes anywhere but settle
   assert_hold_exit_R4: assert property (@(posedge clk) disable iff (arst)
      (phase == PH_HOLD) |=> (phase == PH_HOLD || phase == PH_SETTLE));

endmodule

// File: rtl/pwrup_seq_hiz.sv
module pwrup_seq_hiz
   import pwrup_seq_pkg::*;
#(
   parameter int unsigned GA_W = 1,
   parameter int unsigned GB_W = 1,
   parameter int unsigned GC_W = 1
) (
   input  logic            clk,
   input  logic            arst,
   input  phase_e          phase_i,
   input  logic            ext_act_i,
   output logic [GA_W-1:0] hiz_a_o,
   output logic [GB_W-1:0] hiz_b_o,
   output logic [GC_W-1:0] hiz_c_o
);

   generate
      if (GA_W < 1 || GB_W < 1 || GC_W < 1) begin : g_bad_width
         $error("pwrup_seq_hiz: group widths must be at least 1");
      end
   endgenerate

   logic in_hold, in_reset, post_hold;

   always_comb begin
      in_hold   = (phase_i == PH_HOLD);
      in_reset  = (phase_i != PH_RUN);
      post_hold = in_reset && !in_hold;
   end

   assign hiz_a_o = {GA_W{in_reset}};
   assign hiz_b_o = {GB_W{(in_hold && ext_act_i) || post_hold}};
   assign hiz_c_o = {GC_W{post_hold}};

   // R9: group C is never forced during the hold
   assert_grpc_quiet_R9: assert property (@(posedge clk) disable iff (arst)
      (phase_i == PH_HOLD) |-> (hiz_c_o == '0));

   // R7: group A covers every cycle of reset
   assert_grpa_cover_R7: assert property (@(posedge clk) disable iff (arst)
      (phase_i != PH_RUN) |-> (&hiz_a_o));

   // R8: groups A and B are both released while running
   assert_release_all_R8: assert property (@(posedge clk) disable iff (arst)
      (phase_i == PH_RUN) |-> (hiz_a_o == '0 && hiz_b_o == '0 && hiz_c_o == '0));

endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
   import pwrup_seq_pkg::*;
#(
   parameter int unsigned POR_EXP     = 17,
   parameter int unsigned STAB_EXP    = 18,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned GA_W        = 8,
   parameter int unsigned GB_W        = 8,
   parameter int unsigned GC_W        = 8
) (
   input  logic            osc_clk,
   input  logic            por_det,
   input  logic            ext_rst_n,
   output logic            int_rst_n,
   output logic            clk_en,
   output logic [GA_W-1:0] hiz_a,
   output logic [GB_W-1:0] hiz_b,
   output logic [GC_W-1:0] hiz_c
);

   logic   ext_sync_n;
   logic   ext_act;
   phase_e phase;

   pwrup_seq_sync #(
      .STAGES   (SYNC_STAGES),
      .INIT_VAL (1'b1)
   ) u_sync (
      .clk  (osc_clk),
      .arst (por_det),
      .d_i  (ext_rst_n),
      .q_o  (ext_sync_n)
   );

   assign ext_act = ~ext_sync_n;

   pwrup_seq_fsm #(
      .POR_EXP  (POR_EXP),
      .STAB_EXP (STAB_EXP)
   ) u_fsm (
      .clk       (osc_clk),
      .arst      (por_det),
      .ext_act_i (ext_act),
      .phase_o   (phase)
   );

   pwrup_seq_hiz #(
      .GA_W (GA_W),
      .GB_W (GB_W),
      .GC_W (GC_W)
   ) u_hiz (
      .clk       (osc_clk),
      .arst      (por_det),
      .phase_i   (phase),
      .ext_act_i (ext_act),
      .hiz_a_o   (hiz_a),
      .hiz_b_o   (hiz_b),
      .hiz_c_o   (hiz_c)
   );

   assign clk_en    = (phase != PH_HOLD);
   assign int_rst_n = (phase == PH_RUN);

   // R6: clocks are running whenever reset is released
   assert_clk_before_rel_R6: assert property (@(posedge osc_clk) disable iff (por_det)
      int_rst_n |-> clk_en);

   // R6: once the clocks have started, only a power-on event stops them
   assert_clk_sticky_R6: assert property (@(posedge osc_clk) disable iff (por_det)
      clk_en |=> clk_en);

endmodule

// File: tb/pwrup_seq_tb.sv
`timescale 1ns/1ps
module pwrup_seq_tb;

   localparam int unsigned POR_EXP  = 4;
   localparam int unsigned STAB_EXP = 5;
   localparam int unsigned GA_W = 3;
   localparam int unsigned GB_W = 2;
   localparam int unsigned GC_W = 4;
   localparam int unsigned HOLD_N   = 1 << POR_EXP;
   localparam int unsigned SETTLE_N = 1 << STAB_EXP;

   logic            osc_clk = 1'b0;
   logic            por_det = 1'b1;
   logic            ext_rst_n = 1'b1;
   logic            int_rst_n, clk_en;
   logic [GA_W-1:0] hiz_a;
   logic [GB_W-1:0] hiz_b;
   logic [GC_W-1:0] hiz_c;

   int n_run  = 0;
   int n_fail = 0;

   always #2.5 osc_clk = ~osc_clk;

   pwrup_seq #(
      .POR_EXP(POR_EXP), .STAB_EXP(STAB_EXP), .SYNC_STAGES(2),
      .GA_W(GA_W), .GB_W(GB_W), .GC_W(GC_W)
   ) u_dut (
      .osc_clk(osc_clk), .por_det(por_det), .ext_rst_n(ext_rst_n),
      .int_rst_n(int_rst_n), .clk_en(clk_en),
      .hiz_a(hiz_a), .hiz_b(hiz_b), .hiz_c(hiz_c)
   );

   // fields: [17:14] req, [13:6] edges, [5] ext_rst_n, [4] rst_n, [3] clk_en, [2] a, [1] b, [0] c
   localparam int NV = 15;
   localparam logic [17:0] VEC [NV] = '{
      {4'd1, 8'd1,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R1 hold begins
      {4'd3, 8'd1,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R3 first flop only
      {4'd8, 8'd1,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R8 B follows ext in hold
      {4'd4, 8'd12, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R4 edge 15, still hold
      {4'd9, 8'd1,  1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},  // R9 edge 16, hold ends
      {4'd5, 8'd1,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},  // R5
      {4'd5, 8'd1,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},  // R5 sync released at 18
      {4'd5, 8'd31, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},  // R5 edge 49
      {4'd5, 8'd1,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R5 edge 50 release
      {4'd6, 8'd1,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R6
      {4'd6, 8'd1,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R6 sync asserted, fsm not yet
      {4'd7, 8'd1,  1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},  // R7 back in reset
      {4'd6, 8'd2,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},  // R6 sync released at 55
      {4'd6, 8'd31, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},  // R6 edge 86
      {4'd6, 8'd1,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}   // R6 edge 87 release
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_all(input string req, input logic r, input logic c,
                          input logic a, input logic b, input logic z);
      chk(req, "int_rst_n", int'(int_rst_n), int'(r));
      chk(req, "clk_en",    int'(clk_en),    int'(c));
      chk(req, "hiz_a",     int'(hiz_a), int'({GA_W{a}}));
      chk(req, "hiz_b",     int'(hiz_b), int'({GB_W{b}}));
      chk(req, "hiz_c",     int'(hiz_c), int'({GC_W{z}}));
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(posedge osc_clk);
      #1;
   endtask

   task automatic release_por();
      @(negedge osc_clk);
      por_det = 1'b0;
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      step(3);
      chk_all("R10", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);   // reset state

      release_por();
      for (int v = 0; v < NV; v++) begin
         ext_rst_n = VEC[v][5];
         step(int'(VEC[v][13:6]));
         chk_all($sformatf("R%0d", VEC[v][17:14]), VEC[v][4], VEC[v][3],
                 VEC[v][2], VEC[v][1], VEC[v][0]);
      end

      // R10: power-on detect acts without a clock edge while running
      step(3);
      por_det = 1'b1;
      #1;
      chk_all("R10", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);

      // R1 and R2: clean sequence with no external reset
      step(2);
      release_por();
      step(HOLD_N - 1);
      chk("R1", "clk_en at last hold edge", int'(clk_en), 0);
      chk("R9", "hiz_c at last hold edge", int'(hiz_c), 0);
      step(1);
      chk("R1", "clk_en at hold end", int'(clk_en), 1);
      step(SETTLE_N - 1);
      chk("R2", "int_rst_n one edge before release", int'(int_rst_n), 0);
      step(1);
      chk("R2", "int_rst_n at release", int'(int_rst_n), 1);
      chk("R7", "hiz_a at release", int'(hiz_a), 0);

      // R3: a one-cycle external pulse still reaches the outputs two edges later
      ext_rst_n = 1'b0;
      step(1);
      ext_rst_n = 1'b1;
      chk("R3", "int_rst_n after one edge", int'(int_rst_n), 1);
      step(2);
      chk("R3", "int_rst_n after sync", int'(int_rst_n), 0);
      chk("R6", "clk_en kept running", int'(clk_en), 1);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule